// File: doc/BRIEF.md
# Burst Ordering Monitor

This block is a passive observer that sits beside an AXI-style port. It watches the write-address, write-data, write-response, read-address and read-data channels. It drives nothing on the port. It reports violations of three kinds of rule: the data-beat count of each burst, which must agree with its length field; the identifier ordering of write data beats; and whether every response has an outstanding request to answer. Each kind of fault has its own error code.

Write data is assumed to follow write addresses in acceptance order, and each address must be accepted in a cycle before its first data beat. A write burst counts as complete when it closes on the data channel. Write responses are matched, per identifier, against completed bursts. Read requests are queued per identifier, so each read data burst is held against the length of the oldest read request still open for that identifier. When a bounded tracking store is full, the overflow is reported as its own fault.

Every fault sets a sticky flag and produces a one-cycle pulse that carries an error code. A synchronous clear input drops the sticky flags. An active-low synchronous reset empties all tracking state.

Top module: `axi_order_mon`

## Requirements
- R1: A transfer on any channel is seen only in a cycle where its valid and ready are both high; a valid without ready has no effect on errors or tracking.
- R2: While a write burst is open, a data beat with a different identifier raises code 1; that beat is otherwise ignored, and the open burst continues.
- R3: Write data bursts take their lengths from accepted write addresses in order. A last beat that is not beat number len+1 raises code 2. So does beat number len+1 without the last marker, and that beat closes the burst. A data beat with no pending address also raises code 2 and is dropped.
- R4: A write response for an identifier that has no completed, unanswered write burst raises code 3.
- R5: Read data beats are counted per identifier against the length of the oldest open read request for that identifier. A count that does not match at the last beat, or a beat number len+1 without last, raises code 4. Either one closes that request and resets the counter to zero.
- R6: A read data beat for an identifier with no open read request raises code 5.
- R7: A request that arrives when its tracking store is full raises code 6 and is not tracked. The stores are the write-address queue, the per-identifier read queue and the per-identifier completed-burst counter.
- R8: In the cycle after a faulty transfer, err_pulse is high and err_code holds the lowest code raised in that cycle. Bit code-1 of err_flags sets and stays set. err_code is 0 when there is no pulse.
- R9: clr_i clears err_flags at the next edge, but faults detected in that same cycle are still recorded.
- R10: Reset clears err_flags, err_pulse, err_code and all tracking state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Clears sticky flags |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | IDW | Write address identifier |
| aw_len | input | LENW | Write burst length minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_id | input | IDW | Write data identifier |
| w_last | input | 1 | Final write beat marker |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | input | IDW | Write response identifier |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | IDW | Read address identifier |
| ar_len | input | LENW | Read burst length minus one |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | IDW | Read data identifier |
| r_last | input | 1 | Final read beat marker |
| err_flags | output | 6 | Sticky fault flags, bit code-1 per code |
| err_pulse | output | 1 | One-cycle fault indication |
| err_code | output | 4 | Code of the reported fault |

## Verification
Writes are exercised with exact-length bursts, bursts that end early, bursts that run past their length, and a foreign-identifier beat in the middle of a burst. These separate the length check from the identifier check and show that an ignored beat leaves the open burst intact. Reads from several identifiers are interleaved with different lengths, which shows that per-identifier counters and oldest-first queues keep the identifiers apart. Stalled handshakes, response floods, full stores, a clear together with a new fault, and two faults in one cycle cover the handshake qualifier, the overflow path, the clear precedence and the code priority.

// File: rtl/aom_pkg.sv
// Shared error codes for the burst ordering monitor.
// Assumes code k maps to sticky flag bit k-1.
package aom_pkg;
    localparam int ERR_NUM = 6;
    localparam int CODE_W  = 4;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE       = 4'd0,
        ERR_W_IDSWITCH = 4'd1,
        ERR_W_BEATS    = 4'd2,
        ERR_B_UNEXP    = 4'd3,
        ERR_R_BEATS    = 4'd4,
        ERR_R_UNEXP    = 4'd5,
        ERR_OVFL       = 4'd6
    } err_code_e;
endpackage

// File: rtl/aom_lenq.sv
// Small circular queue holding burst lengths.
// Assumes the caller never pushes when full or pops when empty;
// a push and a pop may happen in the same cycle.
module aom_lenq #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_push_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);
endmodule

// File: rtl/aom_wr_chk.sv
// Write-side checks: it queues address lengths in acceptance order, counts
// data beats against the queue head, rejects beats from a second identifier
// while a burst is open, and matches responses to completed bursts per identifier.
// Assumes each address is accepted before its first data beat.
module aom_wr_chk #(
    parameter int IDW      = 2,
    parameter int LENW     = 8,
    parameter int WQ_DEPTH = 4,
    parameter int DONE_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            aw_hs,
    input  logic [LENW-1:0] aw_len,
    input  logic            w_hs,
    input  logic [IDW-1:0]  w_id,
    input  logic            w_last,
    input  logic            b_hs,
    input  logic [IDW-1:0]  b_id,
    output logic            err_idswitch,
    output logic            err_beats,
    output logic            err_bunexp,
    output logic            err_ovfl
);
    localparam int NID  = 1 << IDW;
    localparam int BCW  = LENW + 1;

    logic            q_push, q_pop, q_empty, q_full;
    logic [LENW-1:0] q_head;
    logic            burst_open, nxt_open;
    logic [IDW-1:0]  burst_id, nxt_bid;
    logic [BCW-1:0]  beat_cnt, nxt_cnt, beat_num, full_num;
    logic            close;
    logic [NID-1:0]  unexp_v, ov_v;

    assign q_push = aw_hs && !q_full;

    aom_lenq #(.DW(LENW), .DEPTH(WQ_DEPTH)) u_awq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(aw_len),
        .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
    );

    assign beat_num = burst_open ? beat_cnt + 1'b1 : BCW'(1);
    assign full_num = {1'b0, q_head} + 1'b1;

    // classify each accepted data beat and decide burst closure
    always_comb begin
        err_idswitch = 1'b0;
        err_beats    = 1'b0;
        close        = 1'b0;
        q_pop        = 1'b0;
        nxt_open     = burst_open;
        nxt_bid      = burst_id;
        nxt_cnt      = beat_cnt;
        if (w_hs) begin
            if (burst_open && (w_id != burst_id)) begin
                err_idswitch = 1'b1;
            end else if (!burst_open && q_empty) begin
                err_beats = 1'b1;
            end else if (w_last || (beat_num == full_num)) begin
                close     = 1'b1;
                q_pop     = 1'b1;
                nxt_open  = 1'b0;
                nxt_cnt   = '0;
                err_beats = !(w_last && (beat_num == full_num));
            end else begin
                nxt_open = 1'b1;
                nxt_bid  = w_id;
                nxt_cnt  = beat_num;
            end
        end
    end

    // open-burst state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_open <= 1'b0;
            burst_id   <= '0;
            beat_cnt   <= '0;
        end else begin
            burst_open <= nxt_open;
            burst_id   <= nxt_bid;
            beat_cnt   <= nxt_cnt;
        end
    end

    // per-identifier count of completed bursts awaiting a response
    for (genvar g = 0; g < NID; g++) begin : g_done
        logic [DONE_W-1:0] cnt;
        logic inc, dec;
        assign inc        = close && (w_id == IDW'(g));
        assign dec        = b_hs && (b_id == IDW'(g));
        assign unexp_v[g] = dec && (cnt == '0);
        assign ov_v[g]    = inc && (cnt == '1);

        // counter update with saturation at both ends
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else
                cnt <= cnt + DONE_W'(inc && !ov_v[g]) - DONE_W'(dec && !unexp_v[g]);
        end
    end

    assign err_bunexp = |unexp_v;
    assign err_ovfl   = (aw_hs && q_full) || (|ov_v);

    assert_foreign_beat_keeps_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_open && w_hs && (w_id != burst_id)) |=> (burst_open && $stable(burst_id) && $stable(beat_cnt)));
    assert_open_burst_within_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        burst_open |-> (!q_empty && (beat_cnt <= {1'b0, q_head})));
endmodule

// File: rtl/aom_rd_chk.sv
// Read-side checks: it keeps a queue of request lengths per identifier and a
// beat counter per identifier, and closes the oldest request at its last beat.
// Assumes read data for one identifier returns in request order.
module aom_rd_chk #(
    parameter int IDW      = 2,
    parameter int LENW     = 8,
    parameter int RQ_DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ar_hs,
    input  logic [IDW-1:0]  ar_id,
    input  logic [LENW-1:0] ar_len,
    input  logic            r_hs,
    input  logic [IDW-1:0]  r_id,
    input  logic            r_last,
    output logic            err_beats,
    output logic            err_unexp,
    output logic            err_ovfl
);
    localparam int NID = 1 << IDW;
    localparam int BCW = LENW + 1;

    logic [NID-1:0] beats_v, unexp_v, ov_v;

    for (genvar g = 0; g < NID; g++) begin : g_id
        logic            push, pop, empty, full, sel, close;
        logic [LENW-1:0] head;
        logic [BCW-1:0]  cnt, num, full_num;

        assign sel  = r_hs && (r_id == IDW'(g));
        assign push = ar_hs && (ar_id == IDW'(g)) && !full;
        assign ov_v[g] = ar_hs && (ar_id == IDW'(g)) && full;

        aom_lenq #(.DW(LENW), .DEPTH(RQ_DEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .push(push), .push_data(ar_len),
            .pop(pop), .head(head), .empty(empty), .full(full)
        );

        assign num        = cnt + 1'b1;
        assign full_num   = {1'b0, head} + 1'b1;
        assign unexp_v[g] = sel && empty;
        assign close      = sel && !empty && (r_last || (num == full_num));
        assign pop        = close;
        assign beats_v[g] = close && !(r_last && (num == full_num));

        // beat counter for this identifier
        always_ff @(posedge clk) begin
            if (!rst_n)             cnt <= '0;
            else if (close)         cnt <= '0;
            else if (sel && !empty) cnt <= num;
        end

        assert_idle_counter_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            empty |-> (cnt == '0));
        assert_counter_below_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !empty |-> (cnt <= {1'b0, head}));
    end

    assign err_beats = |beats_v;
    assign err_unexp = |unexp_v;
    assign err_ovfl  = |ov_v;
endmodule

// File: rtl/axi_order_mon.sv
// Burst ordering monitor top. It qualifies handshakes, runs the write-side and
// read-side checks, and registers the sticky flags, the pulse and the code.
// Assumes the port is observed only, never driven.
module axi_order_mon
    import aom_pkg::*;
#(
    parameter int IDW      = 2,
    parameter int LENW     = 8,
    parameter int WQ_DEPTH = 4,
    parameter int RQ_DEPTH = 4,
    parameter int DONE_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                aw_valid,
    input  logic                aw_ready,
    input  logic [IDW-1:0]      aw_id,
    input  logic [LENW-1:0]     aw_len,
    input  logic                w_valid,
    input  logic                w_ready,
    input  logic [IDW-1:0]      w_id,
    input  logic                w_last,
    input  logic                b_valid,
    input  logic                b_ready,
    input  logic [IDW-1:0]      b_id,
    input  logic                ar_valid,
    input  logic                ar_ready,
    input  logic [IDW-1:0]      ar_id,
    input  logic [LENW-1:0]     ar_len,
    input  logic                r_valid,
    input  logic                r_ready,
    input  logic [IDW-1:0]      r_id,
    input  logic                r_last,
    output logic [ERR_NUM-1:0]  err_flags,
    output logic                err_pulse,
    output logic [CODE_W-1:0]   err_code
);
    logic aw_hs, w_hs, b_hs, ar_hs, r_hs;
    logic w_idsw, w_beats, b_unexp, w_ovfl;
    logic r_beats, r_unexp, r_ovfl;
    logic [ERR_NUM-1:0] err_new;
    logic [CODE_W-1:0]  code_nxt;

    // R1: a transfer exists only when valid and ready meet
    assign aw_hs = aw_valid && aw_ready;
    assign w_hs  = w_valid  && w_ready;
    assign b_hs  = b_valid  && b_ready;
    assign ar_hs = ar_valid && ar_ready;
    assign r_hs  = r_valid  && r_ready;

    aom_wr_chk #(.IDW(IDW), .LENW(LENW), .WQ_DEPTH(WQ_DEPTH), .DONE_W(DONE_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .aw_hs(aw_hs), .aw_len(aw_len),
        .w_hs(w_hs), .w_id(w_id), .w_last(w_last), .b_hs(b_hs), .b_id(b_id),
        .err_idswitch(w_idsw), .err_beats(w_beats), .err_bunexp(b_unexp), .err_ovfl(w_ovfl)
    );

    aom_rd_chk #(.IDW(IDW), .LENW(LENW), .RQ_DEPTH(RQ_DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .ar_hs(ar_hs), .ar_id(ar_id), .ar_len(ar_len),
        .r_hs(r_hs), .r_id(r_id), .r_last(r_last),
        .err_beats(r_beats), .err_unexp(r_unexp), .err_ovfl(r_ovfl)
    );

    assign err_new = {w_ovfl || r_ovfl, r_unexp, r_beats, b_unexp, w_beats, w_idsw};

    // pick the lowest code raised this cycle
    always_comb begin
        code_nxt = ERR_NONE;
        for (int k = ERR_NUM - 1; k >= 0; k--)
            if (err_new[k]) code_nxt = CODE_W'(k + 1);
    end

    // report registers: sticky flags, pulse, code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flags <= '0;
            err_pulse <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_flags <= (clr_i ? '0 : err_flags) | err_new;
            err_pulse <= |err_new;
            err_code  <= code_nxt;
        end
    end

    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
    assert_code_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse == (err_code != ERR_NONE));
    assert_code_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_code <= CODE_W'(ERR_NUM));
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (err_new == '0)) |=> (err_flags == '0));
    assert_stall_no_error_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!aw_ready && !w_ready && !b_ready && !ar_ready && !r_ready) |=> !err_pulse);
endmodule

// File: tb/tb_axi_order_mon.sv
module tb_axi_order_mon;
    localparam int CLK_PERIOD = 10;
    localparam int IDW  = 2;
    localparam int LENW = 8;
    localparam int WQD  = 4;
    localparam int RQD  = 4;
    localparam int DW   = 3;
    localparam int NID  = 1 << IDW;
    localparam int DMAX = (1 << DW) - 1;

    logic clk = 0, rst_n = 0, clr_i = 0;
    logic aw_valid = 0, aw_ready = 1; logic [IDW-1:0] aw_id = 0; logic [LENW-1:0] aw_len = 0;
    logic w_valid = 0, w_ready = 1;   logic [IDW-1:0] w_id = 0;  logic w_last = 0;
    logic b_valid = 0, b_ready = 1;   logic [IDW-1:0] b_id = 0;
    logic ar_valid = 0, ar_ready = 1; logic [IDW-1:0] ar_id = 0; logic [LENW-1:0] ar_len = 0;
    logic r_valid = 0, r_ready = 1;   logic [IDW-1:0] r_id = 0;  logic r_last = 0;
    logic [5:0] err_flags; logic err_pulse; logic [3:0] err_code;

    int checks = 0, fails = 0;
    bit finished = 0, started = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_order_mon #(.IDW(IDW), .LENW(LENW), .WQ_DEPTH(WQD), .RQ_DEPTH(RQD), .DONE_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
        .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len),
        .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_last(r_last),
        .err_flags(err_flags), .err_pulse(err_pulse), .err_code(err_code));

    // ---------------- behavioural reference model ----------------
    int aw_q[$];
    int rq[NID][$];
    int rcnt[NID];
    int done_c[NID];
    bit w_open; int w_bid, w_cnt;
    logic [5:0] exp_flags = 0; logic exp_pulse = 0; logic [3:0] exp_code = 0;
    logic [5:0] e;
    bit aw_full, r_full, close, bu; int n, len, cid;

    always @(posedge clk) begin
        if (!rst_n) begin
            aw_q.delete();
            for (int i = 0; i < NID; i++) begin rq[i].delete(); rcnt[i] = 0; done_c[i] = 0; end
            w_open = 0; w_bid = 0; w_cnt = 0;
            exp_flags = 0; exp_pulse = 0; exp_code = 0;
        end else begin
            e = 0; close = 0; cid = 0;
            aw_full = (aw_q.size() == WQD);
            r_full  = ar_valid && ar_ready && (rq[ar_id].size() == RQD);
            if (w_valid && w_ready) begin
                if (w_open && int'(w_id) != w_bid) e[0] = 1;
                else if (!w_open && aw_q.size() == 0) e[1] = 1;
                else begin
                    n = w_open ? w_cnt + 1 : 1;
                    len = aw_q[0];
                    if (w_last || n == len + 1) begin
                        if (!(w_last && n == len + 1)) e[1] = 1;
                        void'(aw_q.pop_front());
                        w_open = 0; w_cnt = 0; close = 1; cid = int'(w_id);
                    end else begin
                        w_open = 1; w_bid = int'(w_id); w_cnt = n;
                    end
                end
            end
            if (aw_valid && aw_ready) begin
                if (aw_full) e[5] = 1; else aw_q.push_back(int'(aw_len));
            end
            bu = b_valid && b_ready && done_c[b_id] == 0;
            if (bu) e[2] = 1;
            if (close) begin
                if (done_c[cid] == DMAX) e[5] = 1; else done_c[cid]++;
            end
            if (b_valid && b_ready && !bu) done_c[b_id]--;
            if (r_valid && r_ready) begin
                if (rq[r_id].size() == 0) e[4] = 1;
                else begin
                    n = rcnt[r_id] + 1;
                    len = rq[r_id][0];
                    if (r_last || n == len + 1) begin
                        if (!(r_last && n == len + 1)) e[3] = 1;
                        void'(rq[r_id].pop_front());
                        rcnt[r_id] = 0;
                    end else rcnt[r_id] = n;
                end
            end
            if (ar_valid && ar_ready) begin
                if (r_full) e[5] = 1; else rq[ar_id].push_back(int'(ar_len));
            end
            exp_flags = (clr_i ? 6'b0 : exp_flags) | e;
            exp_pulse = |e;
            exp_code = 0;
            for (int k = 5; k >= 0; k--) if (e[k]) exp_code = 4'(k + 1);
            started = 1;
        end
    end

    // per-cycle comparison, away from the active edge (R8)
    always @(negedge clk) begin
        if (started && !finished) begin
            checks++;
            if (err_flags !== exp_flags || err_pulse !== exp_pulse || err_code !== exp_code) begin
                fails++;
                $display("FAIL R8 per-cycle: flags=%b pulse=%b code=%0d expected flags=%b pulse=%b code=%0d",
                         err_flags, err_pulse, err_code, exp_flags, exp_pulse, exp_code);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input int act, input int expv, input string tag);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic aw(input int id, input int l);
        aw_valid = 1; aw_id = IDW'(id); aw_len = LENW'(l); @(negedge clk); aw_valid = 0;
    endtask
    task automatic wb(input int id, input bit last);
        w_valid = 1; w_id = IDW'(id); w_last = last; @(negedge clk); w_valid = 0; w_last = 0;
    endtask
    task automatic bb(input int id);
        b_valid = 1; b_id = IDW'(id); @(negedge clk); b_valid = 0;
    endtask
    task automatic ar(input int id, input int l);
        ar_valid = 1; ar_id = IDW'(id); ar_len = LENW'(l); @(negedge clk); ar_valid = 0;
    endtask
    task automatic rb(input int id, input bit last);
        r_valid = 1; r_id = IDW'(id); r_last = last; @(negedge clk); r_valid = 0; r_last = 0;
    endtask
    task automatic clr();
        clr_i = 1; @(negedge clk); clr_i = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk(err_flags, 0, "R10 flags"); chk(err_pulse, 0, "R10 pulse"); chk(err_code, 0, "R10 code");

        // R1: valid without ready is invisible
        w_ready = 0; b_ready = 0; r_ready = 0;
        w_valid = 1; w_id = 1; w_last = 1; b_valid = 1; b_id = 2; r_valid = 1; r_id = 3; r_last = 1;
        repeat (3) @(negedge clk);
        w_valid = 0; b_valid = 0; r_valid = 0; w_last = 0; r_last = 0;
        w_ready = 1; b_ready = 1; r_ready = 1;
        chk(err_flags, 0, "R1 stalled transfers");

        // R3 exact length, R4 matched and unexpected responses
        aw(1, 3); wb(1, 0); wb(1, 0); wb(1, 0); wb(1, 1);
        chk(err_flags, 0, "R3 exact length");
        bb(1); chk(err_flags, 0, "R4 matched response");
        bb(1); chk(err_code, 3, "R4 unexpected response code");
        chk(err_flags, 6'b000100, "R4 flag");
        clr();

        // R2: foreign identifier mid-burst is flagged and ignored
        aw(2, 1); wb(2, 0); wb(3, 0);
        chk(err_code, 1, "R2 id switch code");
        wb(2, 1); bb(2);
        chk(err_flags, 6'b000001, "R2 burst continues");
        clr();

        // R3: early last
        aw(0, 3); wb(0, 0); wb(0, 1);
        chk(err_code, 2, "R3 early last");
        bb(0); chk(err_flags, 6'b000010, "R3 early burst still completes");
        clr();

        // R3: overrun without last, then data with no address
        aw(0, 1); wb(0, 0); wb(0, 0);
        chk(err_code, 2, "R3 missing last");
        wb(0, 1); chk(err_code, 2, "R3 data without address");
        bb(0); chk(err_flags, 6'b000010, "R3 overrun closes burst");
        bb(0); chk(err_code, 3, "R4 only one completion");
        clr();

        // R5/R6: interleaved identifiers with different lengths
        ar(1, 2); ar(1, 0); ar(2, 1);
        rb(2, 0); rb(1, 0); rb(1, 0); rb(1, 1); rb(1, 1); rb(2, 1);
        chk(err_flags, 0, "R5 per-id counting");
        rb(1, 1); chk(err_code, 5, "R6 no open read");
        ar(3, 1); rb(3, 1); chk(err_code, 4, "R5 short read burst");
        rb(3, 0); chk(err_code, 5, "R5 counter reset and request closed");
        clr();

        // R7: read store overflow
        for (int i = 0; i < 5; i++) ar(0, 0);
        chk(err_code, 6, "R7 overflow code");
        for (int i = 0; i < 4; i++) rb(0, 1);
        chk(err_flags, 6'b100000, "R7 first four tracked");
        rb(0, 1); chk(err_code, 5, "R7 overflowed request not tracked");
        clr();

        // R7: write address queue overflow
        for (int i = 0; i < 5; i++) aw(1, 0);
        chk(err_code, 6, "R7 write queue overflow");
        for (int i = 0; i < 4; i++) wb(1, 1);
        wb(1, 1); chk(err_code, 2, "R7 fifth address dropped");
        for (int i = 0; i < 4; i++) bb(1);
        clr();

        // R9: clear together with a new fault
        bb(2); chk(err_flags, 6'b000100, "R9 setup");
        clr_i = 1; r_valid = 1; r_id = 2; r_last = 1; @(negedge clk);
        clr_i = 0; r_valid = 0; r_last = 0;
        chk(err_flags, 6'b010000, "R9 clear keeps new fault");
        clr(); chk(err_flags, 0, "R9 clear alone");

        // R8: two faults in one cycle
        b_valid = 1; b_id = 1; r_valid = 1; r_id = 1; r_last = 1; @(negedge clk);
        b_valid = 0; r_valid = 0; r_last = 0;
        chk(err_pulse, 1, "R8 pulse"); chk(err_code, 3, "R8 lowest code wins");
        @(negedge clk);
        chk(err_pulse, 0, "R8 pulse lasts one cycle");
        chk(err_flags, 6'b010100, "R8 both flags sticky");

        repeat (2) @(negedge clk);
        summary();
    end
endmodule